// File: doc/BRIEF.md
# Load-reserved / store-conditional reservation monitor

This block executes the two reservation-based atomic instructions for a single hart. It decodes the 32-bit instruction word, drives a simple request/acknowledge memory port, and holds the hart's one reservation. The reservation is a valid flag plus the address of the naturally aligned 8-byte granule that was last load-reserved. Tracking lives entirely inside the block, and the shared bus is never locked.

A load-reserved reads memory, returns the loaded value for the destination register and records the granule. A store-conditional tests the reservation. If the test passes, it writes memory and returns 0. If it fails, it makes no memory access and returns 1. Either way the reservation is dropped. A snoop port carries the granule address of writes made by other agents, and a hit on the reserved granule cancels the reservation. The block accepts one instruction at a time while `ready` is high. Results come back as a one-cycle `rd_we` pulse with the register index and value.

Top module: `lrsc_monitor`

## Requirements
- R1: An instruction is acted on only when opcode [6:0] is 7'b0101111, funct3 [14:12] is 3'b010 (word) or 3'b011 (doubleword), and funct5 [31:27] is 5'b00010 (load-reserved, with the rs2 field [24:20] zero) or 5'b00011 (store-conditional). Any other word causes no memory request, no result, no fault and no change to the reservation.
- R2: A load-reserved issues one memory read at `rs1_val` with `mem_size` high for a doubleword. In the cycle after `mem_ack`, `rd_we` pulses with `rd_idx` = insn[11:7]. The value is bits [31:0] of `mem_rdata` sign-extended to 64 bits for a word, or all 64 bits for a doubleword.
- R3: A completed load-reserved sets the reservation to the granule `rs1_val[AW-1:3]` and replaces any earlier reservation.
- R4: A store-conditional whose address lies in the reserved granule, while the reservation is valid, issues one memory write of `rs2_val` (low 32 bits for a word) and returns 0 in the cycle after `mem_ack`.
- R5: A store-conditional that fails makes no memory request and returns 1 in the cycle after issue.
- R6: Every aligned store-conditional clears the reservation, whether it succeeds or fails.
- R7: A snoop whose granule equals the reserved granule clears the reservation. A snoop hit in the same cycle as a store-conditional issue makes that store-conditional fail.
- R8: A word address with bits [1:0] nonzero, or a doubleword address with bits [2:0] nonzero, pulses `fault` in the cycle after issue. It makes no memory request, writes no result and leaves the reservation unchanged.
- R9: After reset there is no reservation, `ready` is high, and `mem_req`, `rd_we` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction valid; taken when `ready` is high |
| insn | input | 32 | Instruction word |
| rs1_val | input | AW | Address operand |
| rs2_val | input | 64 | Store data operand |
| ready | output | 1 | Block can accept an instruction |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 1 | 1 = doubleword, 0 = word |
| mem_addr | output | AW | Request address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 64 | Read data, right-justified |
| snoop_valid | input | 1 | Another agent wrote memory |
| snoop_line | input | AW-3 | Granule address of that write |
| rd_we | output | 1 | Destination-register write pulse |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 64 | Destination-register value |
| fault | output | 1 | Misaligned-address pulse |

## Verification
Two events can meet in one cycle: the issue of a store-conditional and a snoop hit on the reserved granule. The bench provokes this by driving `issue` and `snoop_valid` on the same clock edge. It then judges the store-conditional as failed: no memory transaction is counted and the returned value is 1. A second pairing is a snoop hit during the load-reserved read. The bench covers the separate-cycle case by snooping the granule between load and store and expecting failure. It also checks that a snoop to another granule leaves the later store-conditional successful.

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [31:0]   insn,
  input  logic [AW-1:0] rs1_val,
  input  logic [63:0]   rs2_val,
  output logic          ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_size,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [63:0]   mem_rdata,
  input  logic          snoop_valid,
  input  logic [AW-4:0] snoop_line,
  output logic          rd_we,
  output logic [4:0]    rd_idx,
  output logic [63:0]   rd_data,
  output logic          fault
);
  typedef enum logic [1:0] {IDLE, RD_WAIT, WR_WAIT} state_t;
  state_t st;

  logic          res_v;
  logic [AW-4:0] res_g;

  wire        is_atomic = insn[6:0] == 7'b0101111;
  wire        is_dw     = insn[14:12] == 3'b011;
  wire        width_ok  = insn[14:12] == 3'b010 || is_dw;
  wire        is_load   = is_atomic && width_ok && insn[31:27] == 5'b00010 && insn[24:20] == 5'd0;
  wire        is_store  = is_atomic && width_ok && insn[31:27] == 5'b00011;
  wire        misalign  = is_dw ? |rs1_val[2:0] : |rs1_val[1:0];
  wire        unused_ordering = ^insn[26:25];

  assign ready = st == IDLE;
  wire take       = issue && ready;
  wire snoop_hit  = snoop_valid && res_v && snoop_line == res_g;
  wire store_ok   = res_v && res_g == rs1_val[AW-1:3] && !snoop_hit;
  wire load_done  = st == RD_WAIT && mem_ack;
  wire store_done = st == WR_WAIT && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      res_v     <= 1'b0;
      res_g     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_size  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rd_we     <= 1'b0;
      rd_idx    <= '0;
      rd_data   <= '0;
      fault     <= 1'b0;
    end else begin
      rd_we <= 1'b0;
      fault <= 1'b0;

      if (take && (is_load || is_store)) begin
        rd_idx <= insn[11:7];
        if (misalign) begin
          fault <= 1'b1;
        end else if (is_load) begin
          st       <= RD_WAIT;
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_size <= is_dw;
          mem_addr <= rs1_val;
        end else if (store_ok) begin
          st        <= WR_WAIT;
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_size  <= is_dw;
          mem_addr  <= rs1_val;
          mem_wdata <= is_dw ? rs2_val : {32'd0, rs2_val[31:0]};
        end else begin
          rd_we   <= 1'b1;
          rd_data <= 64'd1;
        end
      end

      if (load_done) begin
        st      <= IDLE;
        mem_req <= 1'b0;
        rd_we   <= 1'b1;
        rd_data <= mem_size ? mem_rdata : {{32{mem_rdata[31]}}, mem_rdata[31:0]};
      end
      if (store_done) begin
        st      <= IDLE;
        mem_req <= 1'b0;
        rd_we   <= 1'b1;
        rd_data <= 64'd0;
      end

      if (load_done) begin
        res_g <= mem_addr[AW-1:3];
        res_v <= !(snoop_valid && snoop_line == mem_addr[AW-1:3]);
      end else if (take && is_store && !misalign) begin
        res_v <= 1'b0;
      end else if (snoop_hit) begin
        res_v <= 1'b0;
      end
    end
  end

  AST_STORE_DROPS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_store && !misalign) |=> !res_v); // R6
  AST_SNOOP_DROPS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit && !load_done) |=> !res_v); // R7
  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !mem_req && !rd_we); // R8
  AST_FAULT_KEEPS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (is_load || is_store) && misalign && !snoop_hit) |=> ($stable(res_v) && $stable(res_g))); // R8
  AST_DW_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_size) |-> mem_addr[2:0] == 3'd0); // R8
  AST_FAIL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we && rd_data == 64'd1 && !$past(mem_req)) |-> !mem_req); // R5
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !ready); // R2
endmodule

// File: tb/lrsc_monitor_bench.sv
module lrsc_monitor_bench;
  localparam int AW = 16;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic issue = 0, mem_ack = 0, snoop_valid = 0;
  logic [31:0] insn = 0;
  logic [AW-1:0] rs1_val = 0;
  logic [63:0] rs2_val = 0, mem_rdata = 0;
  logic [AW-4:0] snoop_line = 0;
  logic ready, mem_req, mem_we, mem_size, rd_we, fault;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata, rd_data;
  logic [4:0] rd_idx;

  lrsc_monitor #(.AW(AW)) u_lrsc_monitor (
    .clk, .rst_n, .issue, .insn, .rs1_val, .rs2_val, .ready, .mem_req, .mem_we,
    .mem_size, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata, .snoop_valid,
    .snoop_line, .rd_we, .rd_idx, .rd_data, .fault);

  logic [63:0] mem [16];
  logic [63:0] exp_mem [16];
  int txn = 0, checks = 0, errors = 0;
  bit done = 0;
  bit m_v = 0;
  logic [AW-4:0] m_g = 0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      txn <= txn + 1;
      if (mem_size) mem_rdata <= mem[mem_addr[6:3]];
      else mem_rdata <= mem_addr[2] ? {mem[mem_addr[6:3]][31:0], mem[mem_addr[6:3]][63:32]}
                                   : mem[mem_addr[6:3]];
      if (mem_we) begin
        if (mem_size) mem[mem_addr[6:3]] <= mem_wdata;
        else if (mem_addr[2]) mem[mem_addr[6:3]][63:32] <= mem_wdata[31:0];
        else mem[mem_addr[6:3]][31:0] <= mem_wdata[31:0];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  endtask

  function automatic logic [31:0] enc(input logic [6:0] opc, input logic [4:0] f5,
                                     input logic [2:0] f3, input logic [4:0] r2, input logic [4:0] rd);
    return {f5, 2'b00, r2, 5'd3, f3, rd, opc};
  endfunction

  task automatic run(input logic [31:0] w, input logic [AW-1:0] a, input logic [63:0] d,
                     input bit snp, input logic [AW-4:0] sline);
    bit lr, sc, dw, mis, shit, got_rd, got_f;
    logic [63:0] got_d, exp_d;
    logic [4:0] got_i;
    int t0;
    dw  = w[14:12] == 3'b011;
    lr  = w[6:0] == 7'b0101111 && (w[14:12] == 3'b010 || dw) && w[31:27] == 5'b00010 && w[24:20] == 0;
    sc  = w[6:0] == 7'b0101111 && (w[14:12] == 3'b010 || dw) && w[31:27] == 5'b00011;
    mis = dw ? |a[2:0] : |a[1:0];
    shit = snp && m_v && sline == m_g;
    got_rd = 0; got_f = 0; got_d = 0; got_i = 0;
    while (!ready) @(negedge clk);
    t0 = txn;
    issue = 1; insn = w; rs1_val = a; rs2_val = d; snoop_valid = snp; snoop_line = sline;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 0) begin issue = 0; snoop_valid = 0; end
      if (rd_we) begin got_rd = 1; got_d = rd_data; got_i = rd_idx; end
      if (fault) got_f = 1;
    end
    if (!(lr || sc)) begin
      chk(!got_rd && !got_f, "R1 ignored encoding gave output", {got_rd, got_f}, 0);
      chk(txn == t0, "R1 ignored encoding made access", txn - t0, 0);
      if (shit) m_v = 0;
    end else if (mis) begin
      chk(got_f && !got_rd, "R8 fault pulse", {got_rd, got_f}, 1);
      chk(txn == t0, "R8 no access on fault", txn - t0, 0);
      if (shit) m_v = 0;
    end else if (lr) begin
      exp_d = dw ? exp_mem[a[6:3]] : (a[2] ? {{32{exp_mem[a[6:3]][63]}}, exp_mem[a[6:3]][63:32]}
                                           : {{32{exp_mem[a[6:3]][31]}}, exp_mem[a[6:3]][31:0]});
      chk(got_rd && got_d == exp_d, "R2 load value", got_d, exp_d);
      chk(got_i == w[11:7], "R2 rd index", got_i, w[11:7]);
      chk(txn == t0 + 1, "R2 one read", txn - t0, 1);
      m_v = 1; m_g = a[AW-1:3];
    end else begin
      if (m_v && m_g == a[AW-1:3] && !shit) begin
        chk(got_rd && got_d == 0, "R4 success returns 0", got_d, 0);
        chk(txn == t0 + 1, "R4 one write", txn - t0, 1);
        if (dw) exp_mem[a[6:3]] = d;
        else if (a[2]) exp_mem[a[6:3]][63:32] = d[31:0];
        else exp_mem[a[6:3]][31:0] = d[31:0];
        chk(mem[a[6:3]] == exp_mem[a[6:3]], "R4 memory contents", mem[a[6:3]], exp_mem[a[6:3]]);
      end else begin
        chk(got_rd && got_d == 1, shit ? "R7 same-cycle snoop fails store" : "R5 failure returns 1", got_d, 1);
        chk(txn == t0, "R5 no write on failure", txn - t0, 0);
      end
      m_v = 0; // R6
    end
  endtask

  localparam logic [6:0] OP = 7'b0101111;
  localparam logic [4:0] LR = 5'b00010, SC = 5'b00011;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 64'hF0E1_D2C3_8B4A_7960 ^ (64'(i) * 64'h1357_9BDF_2468_ACE1);
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ready && !mem_req && !rd_we && !fault, "R9 reset state", {ready, mem_req, rd_we, fault}, 4'b1000);
    run(enc(OP, SC, 3'b011, 5'd4, 5'd9), 16'h0040, 64'h1, 0, 0); // R9 no reservation after reset

    for (int f = 2; f <= 3; f++)
      for (int off = 0; off < 8; off++) begin
        run(enc(OP, LR, 3'(f), 5'd0, 5'(off + 1)), 16'h0008 * 16'(off + 1) + 16'(off), 0, 0, 0);
        run(enc(OP, SC, 3'(f), 5'd7, 5'(off + 10)), 16'h0008 * 16'(off + 1) + 16'(off),
            64'hA5A5_0000_5A5A_0000 + 64'(off * 77 + f), 0, 0); // R6, R8
      end

    run(enc(OP, LR, 3'b010, 5'd0, 5'd5), 16'h0014, 0, 0, 0);
    run(enc(OP, SC, 3'b010, 5'd6, 5'd6), 16'h0010, 64'h1234_5678_8765_4321, 0, 0); // R4 other word same granule
    run(enc(OP, SC, 3'b010, 5'd6, 5'd6), 16'h0010, 64'h5, 0, 0);                  // R6 second store fails

    run(enc(OP, LR, 3'b011, 5'd0, 5'd5), 16'h0020, 0, 0, 0);
    run(enc(OP, SC, 3'b011, 5'd6, 5'd6), 16'h0028, 64'h77, 0, 0);                 // R5 other granule

    run(enc(OP, LR, 3'b011, 5'd0, 5'd5), 16'h0020, 0, 0, 0);
    run(enc(OP, LR, 3'b011, 5'd0, 5'd5), 16'h0030, 0, 0, 0);
    run(enc(OP, SC, 3'b011, 5'd6, 5'd6), 16'h0020, 64'h88, 0, 0);                 // R3 replaced
    run(enc(OP, LR, 3'b011, 5'd0, 5'd5), 16'h0030, 0, 0, 0);
    run(enc(OP, SC, 3'b011, 5'd6, 5'd6), 16'h0030, 64'hCAFE_F00D_DEAD_BEEF, 0, 0); // R3

    run(enc(OP, LR, 3'b010, 5'd0, 5'd2), 16'h0048, 0, 0, 0);
    run(32'h0000_0013, 16'h0, 0, 1, 13'h9);                                       // R7 snoop alone
    run(enc(OP, SC, 3'b010, 5'd6, 5'd3), 16'h0048, 64'h99, 0, 0);
    run(enc(OP, LR, 3'b010, 5'd0, 5'd2), 16'h0048, 0, 0, 0);
    run(32'h0000_0013, 16'h0, 0, 1, 13'hA);                                       // R7 snoop miss
    run(enc(OP, SC, 3'b010, 5'd6, 5'd3), 16'h0048, 64'h9A, 0, 0);
    run(enc(OP, LR, 3'b011, 5'd0, 5'd2), 16'h0050, 0, 0, 0);
    run(enc(OP, SC, 3'b011, 5'd6, 5'd3), 16'h0050, 64'hBB, 1, 13'hA);             // R7 same cycle

    run(enc(OP, LR, 3'b011, 5'd0, 5'd2), 16'h0058, 0, 0, 0);
    run(enc(7'b0101011, SC, 3'b011, 5'd6, 5'd3), 16'h0058, 64'h1, 0, 0);           // R1 bad opcode
    run(enc(OP, SC, 3'b000, 5'd6, 5'd3), 16'h0058, 64'h1, 0, 0);                  // R1 bad width
    run(enc(OP, 5'b00001, 3'b011, 5'd6, 5'd3), 16'h0058, 64'h1, 0, 0);            // R1 other funct5
    run(enc(OP, LR, 3'b011, 5'd4, 5'd3), 16'h0010, 64'h1, 0, 0);                  // R1 LR with rs2
    run(enc(OP, LR, 3'b011, 5'd0, 5'd3), 16'h0012, 0, 0, 0);                      // R8 misaligned LR
    run(enc(OP, SC, 3'b010, 5'd6, 5'd3), 16'h005A, 64'h1, 0, 0);                  // R8 misaligned SC
    run(enc(OP, SC, 3'b011, 5'd6, 5'd3), 16'h0058, 64'h0123_4567_89AB_CDEF, 0, 0); // R1 R8 reservation kept

    done = 1;
    summary();
  end
endmodule